// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and drives the command bus from power-up until the memory can take normal traffic. It is released from reset with clock enable low and a NOP on the bus, and it waits there for a start pulse. It then raises clock enable and holds NOP for a programmable settling period. After that it issues the bring-up commands in a fixed order and spaces each one by a programmable number of clock cycles. It drops the bank address and address bus to zero whenever no command is issued.

Two mode register loads frame the sequence. The first requests a DLL reset by forcing address bit 8 high. The last clears that bit. The mode and extended mode register contents come in as parallel inputs. A build-time switch moves the two refreshes so that they sit between the DLL-reset load and the second precharge-all. The done flag rises once two conditions hold: the final load has had its recovery time, and a separate DLL lock window, counted from the DLL-reset load, has run out.

Top module: `ddr_bringup_seq`

## Requirements
- R1: While reset is applied, and afterwards until `start` is sampled high, `cke`=0, the command pins {cs_n,ras_n,cas_n,we_n}=0111 (NOP), `ba`=0, `addr`=0 and `init_done`=0.
- R2: From the cycle after `start` is sampled high, `cke` is 1. Exactly T_WAIT cycles of NOP follow before the first command.
- R3: With ALT_ORDER=0 the commands come in the order precharge-all, extended mode load, mode load with DLL reset, precharge-all, refresh, refresh, final mode load.
- R4: With ALT_ORDER=1 the order is precharge-all, extended mode load, mode load with DLL reset, refresh, refresh, precharge-all, final mode load.
- R5: Command encodings on {cs_n,ras_n,cas_n,we_n} are NOP=0111, precharge=0010, refresh=0001 and mode/extended load=0000. A precharge drives `addr` with only bit 10 set and `ba`=00, so all banks are closed.
- R6: An extended load drives `ba`=01 and `addr`=`ext_code`. A mode load drives `ba`=00 and `addr`=`mode_code`, with bit 8 forced to 1 on the first load and to 0 on the final load.
- R7: Each command lasts one cycle, and every cycle that holds no command is NOP with `ba`=0 and `addr`=0. The next command comes exactly T_RP cycles after a precharge, T_RFC cycles after a refresh and T_MRD cycles after a mode or extended load.
- R8: `init_done` first rises in cycle max(F+T_MRD, D+T_DLL), where F is the cycle of the final mode load and D the cycle of the DLL-reset load. It then stays high until reset, and no further command is issued.
- R9: Once the sequence has started, further `start` pulses are ignored. The command timing and `cke` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins the bring-up when sampled high in idle |
| mode_code | input | ADDR_W | Base mode register contents (bit 8 is overridden) |
| ext_code | input | ADDR_W | Extended mode register contents |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once the device is ready for normal commands |

## Verification
Three copies of the block are instantiated, and each is built so that a different limit sets the done time. In one the DLL window ends last, in one the final-load recovery ends last, and in one every gap is a single cycle, so commands go back to back. A design that took only one of the two done limits would raise the flag early in one copy. A design with an off-by-one in the gap counters would be one cycle off at every command slot, and the copy with single-cycle gaps would show a lost or merged command. Sweeping mode codes with bit 8 both set and clear catches a DLL-reset bit that is passed through rather than forced. Start pulses in the middle of a run catch a sequencer that restarts or stalls.

// File: rtl/ddr_bringup_seq.sv
module ddr_bringup_seq #(
  parameter int ADDR_W    = 13,
  parameter int T_WAIT    = 40000,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 15,
  parameter int T_MRD     = 2,
  parameter int T_DLL     = 200,
  parameter bit ALT_ORDER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] mode_code,
  input  logic [ADDR_W-1:0] ext_code,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CMAX   = imax(imax(T_WAIT, T_DLL), imax(imax(T_RP, T_RFC), T_MRD));
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int DLL_W  = $clog2(T_DLL + 1);
  localparam int STEPS  = 7;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  localparam logic [ADDR_W-1:0] BIT10 = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] BIT8  = ADDR_W'(1) << 8;

  typedef enum logic [2:0] {K_PRE, K_EXT, K_MDLL, K_REF, K_MFIN} op_t;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_DONE} st_t;

  function automatic op_t step_op(logic [2:0] i);
    case (i)
      3'd0:    return K_PRE;
      3'd1:    return K_EXT;
      3'd2:    return K_MDLL;
      3'd3:    return ALT_ORDER ? K_REF : K_PRE;
      3'd4:    return K_REF;
      3'd5:    return ALT_ORDER ? K_PRE : K_REF;
      default: return K_MFIN;
    endcase
  endfunction

  function automatic int gap_of(op_t o);
    case (o)
      K_PRE:   return T_RP;
      K_REF:   return T_RFC;
      default: return T_MRD;
    endcase
  endfunction

  st_t               st;
  logic [2:0]        step;
  logic [CNT_W-1:0]  cnt;
  logic [DLL_W-1:0]  dll_cnt;
  logic              cke_q, done_q;
  logic [3:0]        cmd_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;

  op_t               op;
  logic [3:0]        nx_cmd;
  logic [1:0]        nx_ba;
  logic [ADDR_W-1:0] nx_addr;

  assign op = step_op(step);

  always_comb begin
    nx_cmd  = C_LMR;
    nx_ba   = 2'b00;
    nx_addr = '0;
    case (op)
      K_PRE:  begin nx_cmd = C_PRE; nx_addr = BIT10; end
      K_EXT:  begin nx_ba = 2'b01; nx_addr = ext_code; end
      K_MDLL: nx_addr = mode_code | BIT8;
      K_REF:  nx_cmd = C_REF;
      default: nx_addr = mode_code & ~BIT8;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= '0;
      cnt     <= '0;
      dll_cnt <= '0;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= C_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      cmd_q  <= C_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (dll_cnt != '0) dll_cnt <= dll_cnt - DLL_W'(1);
      case (st)
        S_IDLE: if (start) begin
          cke_q <= 1'b1;
          cnt   <= CNT_W'(T_WAIT - 1);
          st    <= S_RUN;
        end
        S_RUN: if (cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
        end else begin
          cmd_q  <= nx_cmd;
          ba_q   <= nx_ba;
          addr_q <= nx_addr;
          cnt    <= CNT_W'(gap_of(op) - 1);
          if (op == K_MDLL) dll_cnt <= DLL_W'(T_DLL - 1);
          step   <= step + 3'd1;
          if (int'(step) == STEPS - 1) st <= S_FIN;
        end
        S_FIN: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else if (dll_cnt == '0) begin
            done_q <= 1'b1;
            st     <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign cke       = cke_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign init_done = done_q;

endmodule

// File: rtl/ddr_bringup_seq_chk.sv
module ddr_bringup_seq_chk #(
  parameter int ADDR_W  = 13,
  parameter int MIN_GAP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  logic [3:0] cmd;
  logic       lmr, pre, dll_seen;
  assign cmd = {cs_n, ras_n, cas_n, we_n};
  assign lmr = (cmd == 4'b0000);
  assign pre = (cmd == 4'b0010);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dll_seen <= 1'b0;
    else if (lmr && ba == 2'b00) dll_seen <= 1'b1;

  p_idle_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == 4'b0111 && !init_done));

  p_cke_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> (addr == (ADDR_W'(1) << 10) && ba == 2'b00));

  p_load_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> !ba[1]);

  p_dll_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr && ba == 2'b00 && !dll_seen) |-> addr[8]);

  p_dll_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr && ba == 2'b00 && dll_seen) |-> !addr[8]);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == 4'b0111 && cke));

  generate if (MIN_GAP > 1) begin : g_gap
    p_single_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != 4'b0111) |=> (cmd == 4'b0111 && addr == '0 && ba == 2'b00));
  end endgenerate
endmodule

bind ddr_bringup_seq ddr_bringup_seq_chk #(
  .ADDR_W (ADDR_W),
  .MIN_GAP((T_RP < T_RFC ? (T_RP < T_MRD ? T_RP : T_MRD) : (T_RFC < T_MRD ? T_RFC : T_MRD)))
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/sim_ddr_bringup_seq.sv
module sim_ddr_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int ND = 3;
  localparam int TW [ND] = '{12, 5, 1};
  localparam int RP [ND] = '{3, 2, 1};
  localparam int RFC[ND] = '{5, 4, 1};
  localparam int MRD[ND] = '{2, 6, 1};
  localparam int DLL[ND] = '{20, 4, 9};
  localparam bit ALT[ND] = '{1'b0, 1'b1, 1'b0};

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] mc = '0, ec = '0;
  logic [20:0] got [ND];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic k0, s0, r0, c0, w0, d0, k1, s1, r1, c1, w1, d1, k2, s2, r2, c2, w2, d2;
  logic [1:0] b0, b1, b2;
  logic [AW-1:0] a0, a1, a2;

  ddr_bringup_seq #(.ADDR_W(AW), .T_WAIT(12), .T_RP(3), .T_RFC(5), .T_MRD(2), .T_DLL(20), .ALT_ORDER(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mc), .ext_code(ec),
    .cke(k0), .cs_n(s0), .ras_n(r0), .cas_n(c0), .we_n(w0), .ba(b0), .addr(a0), .init_done(d0));
  ddr_bringup_seq #(.ADDR_W(AW), .T_WAIT(5), .T_RP(2), .T_RFC(4), .T_MRD(6), .T_DLL(4), .ALT_ORDER(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mc), .ext_code(ec),
    .cke(k1), .cs_n(s1), .ras_n(r1), .cas_n(c1), .we_n(w1), .ba(b1), .addr(a1), .init_done(d1));
  ddr_bringup_seq #(.ADDR_W(AW), .T_WAIT(1), .T_RP(1), .T_RFC(1), .T_MRD(1), .T_DLL(9), .ALT_ORDER(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mc), .ext_code(ec),
    .cke(k2), .cs_n(s2), .ras_n(r2), .cas_n(c2), .we_n(w2), .ba(b2), .addr(a2), .init_done(d2));

  assign got[0] = {k0, s0, r0, c0, w0, b0, a0, d0};
  assign got[1] = {k1, s1, r1, c1, w1, b1, a1, d1};
  assign got[2] = {k2, s2, r2, c2, w2, b2, a2, d2};

  // ops: 0 precharge, 1 extended load, 2 DLL-reset load, 3 refresh, 4 final load
  function automatic int op_at(bit alt, int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return alt ? 3 : 0;
      4: return 3;
      5: return alt ? 0 : 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [20:0] expect_vec(int k, int t, bit pulse_run, output string tag);
    int tc, dll_t, fin_t, done_t, op, gap;
    logic [20:0] v;
    v = {1'b0, 4'b0111, 2'b00, 13'd0, 1'b0};
    tag = "R1";
    if (t < 1) return v;
    v[20] = 1'b1;
    tag = (t <= TW[k]) ? "R2" : "R7";
    tc = TW[k] + 1; dll_t = 0; fin_t = 0;
    for (int i = 0; i < 7; i++) begin
      op = op_at(ALT[k], i);
      if (op == 2) dll_t = tc;
      if (i == 6) fin_t = tc;
      if (t == tc) begin
        case (op)
          0: begin v[19:16] = 4'b0010; v[13:1] = 13'h0400; tag = "R5"; end
          1: begin v[19:16] = 4'b0000; v[15:14] = 2'b01; v[13:1] = ec; tag = "R6"; end
          2: begin v[19:16] = 4'b0000; v[13:1] = mc | 13'h0100; tag = "R6"; end
          3: begin v[19:16] = 4'b0001; tag = ALT[k] ? "R4" : "R3"; end
          default: begin v[19:16] = 4'b0000; v[13:1] = mc & ~13'h0100; tag = "R6"; end
        endcase
      end
      gap = (op == 0) ? RP[k] : (op == 3) ? RFC[k] : MRD[k];
      tc += gap;
    end
    done_t = (fin_t + MRD[k] > dll_t + DLL[k]) ? fin_t + MRD[k] : dll_t + DLL[k];
    if (t >= done_t) begin v[0] = 1'b1; tag = "R8"; end
    if (pulse_run && t >= 15) tag = "R9";
    return v;
  endfunction

  task automatic check_all(int t, bit pulse_run);
    string tag;
    logic [20:0] e;
    for (int k = 0; k < ND; k++) begin
      e = expect_vec(k, t, pulse_run, tag);
      checks++;
      if (got[k] !== e) begin
        errors++;
        $display("FAIL %s dut%0d t=%0d got=%h expected=%h", tag, k, t, got[k], e);
      end
    end
  endtask

  initial begin
    for (int r = 0; r < 6; r++) begin
      rst_n = 0;
      start = 0;
      mc = 13'(13'h0a5 + r * 13'h3c7);
      if (r % 2 == 0) mc = mc | 13'h0100; else mc = mc & ~13'h0100;
      ec = 13'(13'h1f0f ^ (r * 13'h0b3));
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_all(0, 1'b0);          // R1 under reset
      rst_n = 1;
      for (int i = 0; i < 2 + r; i++) begin
        @(negedge clk);
        check_all(0, 1'b0);        // R1 idle until start
      end
      start = 1;
      for (int t = 1; t <= 45; t++) begin
        @(negedge clk);
        check_all(t, r >= 3);
        if (t == 1) start = 0;
        if (r >= 3 && (t == 15 || t == 27)) start = 1;   // R9 stray starts
        if (r >= 3 && (t == 16 || t == 28)) start = 0;
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule